// File: doc/BRIEF.md
# Multi-Channel Burst Conversion Sequencer

This block is the digital control core of a serial-attached converter with several analog inputs. A host sends command bytes through a byte-wide slave port, and the block returns bytes through the same port. The shift-register bit timing sits outside the block and presents whole bytes. Each command selects an input channel, a reference source and a gain code. It asks either for a single conversion (demand) or for an endless stream of conversions (burst). The block drives an abstract converter through a start/done handshake. It presents every 10-bit result as a high byte followed by a low byte.

In demand mode the command is echoed and one result pair follows. In burst mode only the first command is echoed. Later burst commands are not echoed. A new channel is appended to a round-robin rotation, and a channel already in the rotation has its stored reference and gain replaced. The output then interleaves result pairs of all enrolled channels in the order they joined. Each channel keeps its own settings record, which is driven to the converter before that channel's conversion starts.

Top module: `burst_adc_seq`

## Requirements
- R1: A command byte has bit 7 as a marker (must be 1), bit 6 as mode (1 demand, 0 burst), bits 5:4 as channel, bit 3 as reference select (0 external, 1 internal) and bits 2:0 as gain code. A byte with bit 7 clear, or a channel number of NUM_CH or above, causes no echo, no conversion and no change to the output stream.
- R2: In idle, a valid demand command is echoed unchanged, followed by exactly one result pair for that channel using the byte's reference and gain. After that, no byte is offered until the next command.
- R3: A result pair is a high byte {0, channel[1:0], result[9:5]} followed by a low byte {000, result[4:0]}, so a full-scale result reassembles to 1023.
- R4: In idle, a valid burst command is echoed once. Result pairs for its channel then follow without end.
- R5: While a burst runs, a burst command for a channel not yet enrolled is not echoed. That channel is appended to the rotation, and pairs follow in enrollment order, up to LIST_DEPTH channels.
- R6: A burst command for an already enrolled channel replaces that channel's stored reference and gain without echo and without changing the rotation.
- R7: Each conversion raises conv_start for one cycle with conv_chan, conv_ref and conv_gain equal to that channel's settings. These are held stable until conv_done.
- R8: While a burst runs, demand commands are ignored. While a demand request is in progress, every incoming byte is ignored.
- R9: Reset clears the rotation, any pending echo and any offered byte. The first burst command after reset is echoed and streams only its own channel.
- R10: An offered byte stays stable on tx_data until the host asserts tx_take, and the stream advances by exactly one byte per take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a byte arrived from the host |
| rx_byte | input | 8 | Byte received from the host |
| tx_valid | output | 1 | A byte is offered to the host |
| tx_data | output | 8 | Offered byte (echo or result half) |
| tx_take | input | 1 | Host consumes the offered byte |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 2 | Channel for the running conversion |
| conv_ref | output | 1 | Reference select for the running conversion |
| conv_gain | output | 3 | Gain code for the running conversion |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| conv_result | input | RES_W | Conversion result, valid with conv_done |

## Verification
The assertions assume that the converter raises conv_done only while a conversion is outstanding, exactly once per start. They also assume that the host asserts tx_take only in a cycle where tx_valid is high and that rx_valid is a single-cycle strobe. The bench's converter model answers each start with one done pulse a fixed three cycles later. Its host tasks pulse rx_valid for one cycle and raise tx_take only after seeing tx_valid at a falling edge. Results encode the channel, reference and gain seen on the converter pins, so every result pair also shows which settings were applied.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   localparam int BYTE_W   = 8;
   localparam int CHAN_W   = 2;
   localparam int GAIN_W   = 3;
   localparam int SET_W    = 1 + GAIN_W;
   localparam int HI_RES_W = BYTE_W - 1 - CHAN_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ECHO,
      ST_START,
      ST_WAIT,
      ST_HI,
      ST_LO
   } seq_state_t;

   // packed MSB-first: matches the command byte bit layout
   typedef struct packed {
      logic              marker;
      logic              demand;
      logic [CHAN_W-1:0] chan;
      logic              ref_sel;
      logic [GAIN_W-1:0] gain;
   } cmd_byte_t;

   typedef struct packed {
      logic              ref_sel;
      logic [GAIN_W-1:0] gain;
   } chan_set_t;
endpackage

// File: rtl/bsq_cmd_decode.sv
module bsq_cmd_decode
   import bsq_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              cmd_valid,
   output cmd_byte_t         cmd
);
   logic chan_ok;

   assign cmd = cmd_byte_t'(rx_byte);

   generate
      if (NUM_CH == (1 << CHAN_W)) begin : g_all_chan
         assign chan_ok = 1'b1;
      end else begin : g_some_chan
         assign chan_ok = (cmd.chan < CHAN_W'(NUM_CH));
      end
   endgenerate

   assign cmd_valid = rx_valid && cmd.marker && chan_ok;
endmodule

// File: rtl/bsq_roster.sv
module bsq_roster
   import bsq_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enroll,
   input  logic [CHAN_W-1:0] enroll_chan,
   input  chan_set_t         enroll_set,
   input  logic              advance,
   output logic [CHAN_W-1:0] cur_chan,
   output chan_set_t         cur_set
);
   localparam int CNT_W    = $clog2(DEPTH + 1);
   localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SLOTS    = 1 << PTR_W;
   localparam int CH_SLOTS = 1 << CHAN_W;

   logic [SLOTS*CHAN_W-1:0]  slot_flat;
   logic [CH_SLOTS*SET_W-1:0] set_flat;
   logic [SLOTS-1:0]         hit;
   logic [CNT_W-1:0]         count_q;
   logic [PTR_W-1:0]         ptr_q;
   logic [CNT_W-1:0]         ptr_ext;
   logic                     in_list;
   logic                     room;
   logic                     append;
   logic                     store;

   generate
      if (DEPTH < 1 || DEPTH > NUM_CH) begin : g_bad_depth
         $error("bsq_roster: DEPTH must lie in 1..NUM_CH");
      end
   endgenerate

   assign in_list = |hit;
   assign room    = (count_q < CNT_W'(DEPTH));
   assign append  = enroll && !in_list && room;
   assign store   = enroll && (in_list || room);
   assign ptr_ext = CNT_W'(ptr_q);

   // rotation slots, filled in enrollment order
   generate
      for (genvar j = 0; j < SLOTS; j++) begin : g_slot
         if (j < DEPTH) begin : g_live
            logic [CHAN_W-1:0] slot_r;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  slot_r <= '0;
               end else if (append && count_q == CNT_W'(j)) begin
                  slot_r <= enroll_chan;
               end
            end
            assign hit[j] = (CNT_W'(j) < count_q) && (slot_r == enroll_chan);
            assign slot_flat[j*CHAN_W +: CHAN_W] = slot_r;
         end else begin : g_pad
            assign hit[j] = 1'b0;
            assign slot_flat[j*CHAN_W +: CHAN_W] = '0;
         end
      end
   endgenerate

   // per-channel settings records
   generate
      for (genvar i = 0; i < CH_SLOTS; i++) begin : g_set
         if (i < NUM_CH) begin : g_live
            chan_set_t set_r;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  set_r <= '0;
               end else if (store && enroll_chan == CHAN_W'(i)) begin
                  set_r <= enroll_set;
               end
            end
            assign set_flat[i*SET_W +: SET_W] = set_r;
         end else begin : g_pad
            assign set_flat[i*SET_W +: SET_W] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         ptr_q   <= '0;
      end else begin
         if (append) begin
            count_q <= count_q + CNT_W'(1);
         end
         if (advance) begin
            if (ptr_ext + CNT_W'(1) >= count_q) begin
               ptr_q <= '0;
            end else begin
               ptr_q <= ptr_q + PTR_W'(1);
            end
         end
      end
   end

   assign cur_chan = slot_flat[ptr_q*CHAN_W +: CHAN_W];
   assign cur_set  = chan_set_t'(set_flat[cur_chan*SET_W +: SET_W]);

   // R5
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   // R5
   ptr_in_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q != '0) |-> (ptr_ext < count_q));
endmodule

// File: rtl/bsq_conv_port.sv
module bsq_conv_port
   import bsq_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CHAN_W-1:0] go_chan,
   input  chan_set_t         go_set,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              conv_ref,
   output logic [GAIN_W-1:0] conv_gain,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic              res_valid,
   output logic [RES_W-1:0]  res_q
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conv_start <= 1'b0;
         conv_chan  <= '0;
         conv_ref   <= 1'b0;
         conv_gain  <= '0;
         busy_q     <= 1'b0;
         res_valid  <= 1'b0;
         res_q      <= '0;
      end else begin
         conv_start <= go;
         res_valid  <= conv_done && busy_q;
         if (go) begin
            conv_chan <= go_chan;
            conv_ref  <= go_set.ref_sel;
            conv_gain <= go_set.gain;
            busy_q    <= 1'b1;
         end else if (conv_done) begin
            busy_q    <= 1'b0;
         end
         if (conv_done && busy_q) begin
            res_q <= conv_result;
         end
      end
   end

   // R7
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !conv_done) |=>
         ($stable(conv_chan) && $stable(conv_ref) && $stable(conv_gain)));

   // R7
   done_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> busy_q);
endmodule

// File: rtl/burst_adc_seq.sv
module burst_adc_seq
   import bsq_pkg::*;
#(
   parameter int NUM_CH     = 3,
   parameter int LIST_DEPTH = 3,
   parameter int RES_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   input  logic             tx_take,
   output logic             conv_start,
   output logic [1:0]       conv_chan,
   output logic             conv_ref,
   output logic [2:0]       conv_gain,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_result
);
   localparam int LO_RES_W = RES_W - HI_RES_W;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << CHAN_W)) begin : g_bad_ch
         $error("burst_adc_seq: NUM_CH out of range");
      end
      if (LO_RES_W < 1 || LO_RES_W > BYTE_W) begin : g_bad_res
         $error("burst_adc_seq: RES_W does not fit two bytes");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [7:0]        echo_q;
   logic              burst_q;
   logic              demand_q;
   logic [CHAN_W-1:0] dem_chan_q;
   chan_set_t         dem_set_q;

   logic              cmd_valid;
   cmd_byte_t         cmd;
   logic              start_burst, start_demand, end_demand;
   logic              enroll, advance, go;
   logic [CHAN_W-1:0] cur_chan, go_chan;
   chan_set_t         cur_set, go_set, cmd_set;
   logic              res_valid;
   logic [RES_W-1:0]  res_q;
   logic [7:0]        hi_byte, lo_byte;

   bsq_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .cmd_valid (cmd_valid),
      .cmd       (cmd)
   );

   assign cmd_set = '{ref_sel: cmd.ref_sel, gain: cmd.gain};

   bsq_roster #(.NUM_CH(NUM_CH), .DEPTH(LIST_DEPTH)) u_roster (
      .clk         (clk),
      .rst_n       (rst_n),
      .enroll      (enroll),
      .enroll_chan (cmd.chan),
      .enroll_set  (cmd_set),
      .advance     (advance),
      .cur_chan    (cur_chan),
      .cur_set     (cur_set)
   );

   assign go_chan = demand_q ? dem_chan_q : cur_chan;
   assign go_set  = demand_q ? dem_set_q  : cur_set;

   bsq_conv_port #(.RES_W(RES_W)) u_conv (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .go_chan     (go_chan),
      .go_set      (go_set),
      .conv_start  (conv_start),
      .conv_chan   (conv_chan),
      .conv_ref    (conv_ref),
      .conv_gain   (conv_gain),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .res_valid   (res_valid),
      .res_q       (res_q)
   );

   // result packing: channel tag travels with the upper bits
   assign hi_byte = {1'b0, conv_chan, res_q[RES_W-1 -: HI_RES_W]};
   generate
      if (LO_RES_W == BYTE_W) begin : g_lo_full
         assign lo_byte = res_q[LO_RES_W-1:0];
      end else begin : g_lo_pad
         assign lo_byte = {{(BYTE_W-LO_RES_W){1'b0}}, res_q[LO_RES_W-1:0]};
      end
   endgenerate

   always_comb begin
      state_d      = state_q;
      go           = 1'b0;
      enroll       = 1'b0;
      advance      = 1'b0;
      tx_valid     = 1'b0;
      tx_data      = '0;
      start_burst  = 1'b0;
      start_demand = 1'b0;
      end_demand   = 1'b0;

      if (state_q == ST_IDLE && cmd_valid) begin
         state_d = ST_ECHO;
         if (cmd.demand) begin
            start_demand = 1'b1;
         end else begin
            start_burst = 1'b1;
            enroll      = 1'b1;
         end
      end else if (burst_q && cmd_valid && !cmd.demand) begin
         enroll = 1'b1;
      end

      case (state_q)
         ST_ECHO: begin
            tx_valid = 1'b1;
            tx_data  = echo_q;
            if (tx_take) state_d = ST_START;
         end
         ST_START: begin
            go      = 1'b1;
            state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (res_valid) state_d = ST_HI;
         end
         ST_HI: begin
            tx_valid = 1'b1;
            tx_data  = hi_byte;
            if (tx_take) state_d = ST_LO;
         end
         ST_LO: begin
            tx_valid = 1'b1;
            tx_data  = lo_byte;
            if (tx_take) begin
               if (demand_q) begin
                  end_demand = 1'b1;
                  state_d    = ST_IDLE;
               end else begin
                  advance = 1'b1;
                  state_d = ST_START;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         echo_q     <= '0;
         burst_q    <= 1'b0;
         demand_q   <= 1'b0;
         dem_chan_q <= '0;
         dem_set_q  <= '0;
      end else begin
         state_q <= state_d;
         if (start_burst || start_demand) begin
            echo_q <= rx_byte;
         end
         if (start_burst) begin
            burst_q <= 1'b1;
         end
         if (start_demand) begin
            demand_q   <= 1'b1;
            dem_chan_q <= cmd.chan;
            dem_set_q  <= cmd_set;
         end else if (end_demand) begin
            demand_q <= 1'b0;
         end
      end
   end

   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_take) |=> (tx_valid && $stable(tx_data)));

   // R10
   take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> tx_valid);

   // R4
   no_reecho_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ECHO) |-> (!$past(burst_q) || $past(state_q == ST_ECHO)));

   // R8
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_q) |-> !demand_q);
endmodule

// File: tb/burst_adc_seq_test.sv
`timescale 1ns/1ps
module burst_adc_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_take = 1'b0;
   logic       conv_start;
   logic [1:0] conv_chan;
   logic       conv_ref;
   logic [2:0] conv_gain;
   logic       conv_done = 1'b0;
   logic [9:0] conv_result = '0;

   logic       fs_mode = 1'b0;
   logic [2:0] lat_cnt = '0;
   int         n_checks = 0;
   int         n_fail = 0;
   bit         finished = 0;

   always #10 clk = ~clk;

   burst_adc_seq uut (
      .clk (clk), .rst_n (rst_n),
      .rx_valid (rx_valid), .rx_byte (rx_byte),
      .tx_valid (tx_valid), .tx_data (tx_data), .tx_take (tx_take),
      .conv_start (conv_start), .conv_chan (conv_chan),
      .conv_ref (conv_ref), .conv_gain (conv_gain),
      .conv_done (conv_done), .conv_result (conv_result)
   );

   // converter model: done three cycles after start, result tags the pin settings
   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (!rst_n) begin
         lat_cnt <= '0;
      end else if (conv_start) begin
         lat_cnt <= 3'd3;
      end else if (lat_cnt != 0) begin
         lat_cnt <= lat_cnt - 3'd1;
         if (lat_cnt == 3'd1) begin
            conv_done   <= 1'b1;
            conv_result <= fs_mode ? 10'h3FF : {conv_gain, conv_ref, conv_chan, 4'h6};
         end
      end
   end

   function automatic logic [9:0] model_res(input logic [1:0] ch, input logic rf, input logic [2:0] g);
      return fs_mode ? 10'h3FF : {g, rf, ch, 4'h6};
   endfunction

   function automatic logic [7:0] exp_hi(input logic [1:0] ch, input logic rf, input logic [2:0] g);
      logic [9:0] r;
      r = model_res(ch, rf, g);
      return {1'b0, ch, r[9:5]};
   endfunction

   function automatic logic [7:0] exp_lo(input logic [1:0] ch, input logic rf, input logic [2:0] g);
      logic [9:0] r;
      r = model_res(ch, rf, g);
      return {3'b000, r[4:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic get_byte(output logic [7:0] b, output bit ok);
      ok = 0;
      b  = '0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (tx_valid) begin
            ok = 1;
            break;
         end
      end
      if (ok) begin
         b = tx_data;
         tx_take = 1'b1;
         @(negedge clk);
         tx_take = 1'b0;
      end
   endtask

   task automatic get_pair(output logic [7:0] hi, output logic [7:0] lo, output bit ok);
      bit ok2;
      get_byte(hi, ok);
      get_byte(lo, ok2);
      ok = ok && ok2;
   endtask

   task automatic expect_pair(input logic [1:0] ch, input logic rf, input logic [2:0] g, input string tag);
      logic [7:0] hi, lo;
      bit ok;
      get_pair(hi, lo, ok);
      check(ok, {tag, " pair offered"}, int'(ok), 1);
      check(hi == exp_hi(ch, rf, g), {tag, " high byte"}, hi, exp_hi(ch, rf, g));
      check(lo == exp_lo(ch, rf, g), {tag, " low byte"}, lo, exp_lo(ch, rf, g));
   endtask

   task automatic expect_echo(input logic [7:0] b, input string tag);
      logic [7:0] got;
      bit ok;
      get_byte(got, ok);
      check(ok && got == b, {tag, " echo"}, got, b);
   endtask

   task automatic expect_silence(input int cycles, input string tag);
      bit seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tx_valid) seen = 1;
      end
      check(!seen, {tag, " no byte offered"}, int'(seen), 0);
   endtask

   task automatic t_reset_state();
      repeat (2) @(negedge clk);
      check(tx_valid == 1'b0, "R9 tx_valid in reset", tx_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0 && conv_start == 1'b0, "R9 idle after reset",
            {tx_valid, conv_start}, 0);
   endtask

   task automatic t_demand_basic();
      // 0xC3: demand, channel 0, external reference, gain 3
      send_byte(8'hC3);
      expect_echo(8'hC3, "R2");
      expect_pair(2'd0, 1'b0, 3'd3, "R2 R3 R7 demand ch0");
      expect_silence(20, "R2 after demand");
   endtask

   task automatic t_full_scale();
      logic [7:0] hi, lo;
      bit ok;
      fs_mode = 1'b1;
      send_byte(8'hE1);
      expect_echo(8'hE1, "R2 full scale");
      get_pair(hi, lo, ok);
      check(ok && hi == 8'h5F, "R3 full-scale high", hi, 8'h5F);
      check(ok && ({hi[4:0], lo[4:0]} == 10'd1023), "R3 full-scale value",
            {hi[4:0], lo[4:0]}, 1023);
      fs_mode = 1'b0;
      expect_silence(10, "R2 after full scale");
   endtask

   task automatic t_ignored_idle();
      send_byte(8'h43);   // marker clear
      send_byte(8'hB0);   // burst, channel 3 not present
      expect_silence(30, "R1 ignored in idle");
   endtask

   task automatic t_demand_busy();
      send_byte(8'hD4);   // demand, channel 1, gain 4
      expect_echo(8'hD4, "R8 demand");
      send_byte(8'h90);   // burst ch1 while demand runs: ignored
      expect_pair(2'd1, 1'b0, 3'd4, "R8 demand ch1");
      expect_silence(30, "R8 burst during demand ignored");
   endtask

   task automatic t_burst_first();
      send_byte(8'h91);   // burst, ch1, ext ref, gain 1
      expect_echo(8'h91, "R4");
      for (int k = 0; k < 3; k++) expect_pair(2'd1, 1'b0, 3'd1, "R4 ch1 stream");
   endtask

   task automatic t_burst_join();
      logic [7:0] hi, lo;
      bit ok, found;
      found = 0;
      send_byte(8'hAD);   // burst, ch2, internal ref, gain 5
      for (int k = 0; k < 4; k++) begin
         get_pair(hi, lo, ok);
         if (ok && hi[6:5] == 2'd2) begin
            found = 1;
            check(hi == exp_hi(2, 1, 5) && lo == exp_lo(2, 1, 5), "R5 R7 ch2 joined",
                  {hi, lo}, {exp_hi(2, 1, 5), exp_lo(2, 1, 5)});
            break;
         end
         check(ok && hi == exp_hi(1, 0, 1), "R5 no echo, ch1 before join", hi, exp_hi(1, 0, 1));
      end
      check(found, "R5 ch2 enrolled", int'(found), 1);
      expect_pair(2'd1, 1'b0, 3'd1, "R5 rotation ch1");
      expect_pair(2'd2, 1'b1, 3'd5, "R5 rotation ch2");
      expect_pair(2'd1, 1'b0, 3'd1, "R5 rotation ch1 again");
      expect_pair(2'd2, 1'b1, 3'd5, "R5 rotation ch2 again");
   endtask

   task automatic t_burst_update();
      logic [7:0] hi, lo;
      bit ok, found;
      found = 0;
      send_byte(8'h9F);   // burst, ch1, internal ref, gain 7
      for (int k = 0; k < 4; k++) begin
         get_pair(hi, lo, ok);
         check(ok && hi[7] == 1'b0, "R6 no echo on update", hi[7], 0);
         if (ok && hi == exp_hi(1, 1, 7) && lo == exp_lo(1, 1, 7)) begin
            found = 1;
            break;
         end
      end
      check(found, "R6 new ch1 settings applied", int'(found), 1);
      expect_pair(2'd2, 1'b1, 3'd5, "R6 rotation kept ch2");
      expect_pair(2'd1, 1'b1, 3'd7, "R6 rotation kept ch1");
      expect_pair(2'd2, 1'b1, 3'd5, "R6 rotation kept ch2 again");
   endtask

   task automatic t_stream_ignore();
      send_byte(8'h2A);   // marker clear
      send_byte(8'hC0);   // demand while burst: ignored
      send_byte(8'hB5);   // channel 3: ignored
      expect_pair(2'd1, 1'b1, 3'd7, "R8 R1 stream unchanged ch1");
      expect_pair(2'd2, 1'b1, 3'd5, "R8 R1 stream unchanged ch2");
      expect_pair(2'd1, 1'b1, 3'd7, "R8 R1 stream unchanged ch1 again");
      expect_pair(2'd2, 1'b1, 3'd5, "R8 R1 stream unchanged ch2 again");
   endtask

   task automatic t_burst_third();
      send_byte(8'h82);   // burst, ch0, ext ref, gain 2
      for (int k = 0; k < 2; k++) begin
         expect_pair(2'd1, 1'b1, 3'd7, "R5 three-way ch1");
         expect_pair(2'd2, 1'b1, 3'd5, "R5 three-way ch2");
         expect_pair(2'd0, 1'b0, 3'd2, "R5 three-way ch0");
      end
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0 && conv_start == 1'b0, "R9 outputs cleared in reset",
            {tx_valid, conv_start}, 0);
      rst_n = 1'b1;
      expect_silence(20, "R9 no stream after reset");
      send_byte(8'hA2);   // burst, ch2, ext ref, gain 2
      expect_echo(8'hA2, "R9 first burst echoed");
      for (int k = 0; k < 3; k++) expect_pair(2'd2, 1'b0, 3'd2, "R9 list cleared, only ch2");
   endtask

   initial begin
      t_reset_state();
      t_demand_basic();
      t_full_scale();
      t_ignored_idle();
      t_demand_busy();
      t_burst_first();
      t_burst_join();
      t_burst_update();
      t_stream_ignore();
      t_burst_third();
      t_reset_mid();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule